// File: doc/BRIEF.md
# Socket Power Fault Latch and Alert Controller

This block gathers fault reports from the supply and programming switches of one or two card sockets, plus one catastrophic indication that covers thermal overload and supply undervoltage. An overcurrent report only counts once it has persisted for a programmable number of clock cycles. The catastrophic report counts at once. The first qualified event is captured in an 8-bit status byte and pulls an active-low alert line.

The alert and the status byte are cleared by two separate pulses from the serial bus slave. The first pulse marks the end of an alert-response read and carries a flag that says whether this device won arbitration on that read. The second pulse marks the end of a status-byte read. A mask input makes the block ignore all faults. The block does no analog sensing and does not decode the bus protocol.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After reset the alert line is released (`alert_n`=1), `pending` is 0, and status bits 7..3 are 0.
- R2: An overcurrent input counts as a fault only once it has been high for more than `OC_QUAL_CYC` consecutive clock cycles. With the input high for exactly `OC_QUAL_CYC` cycles, nothing is latched. With it high for `OC_QUAL_CYC`+1 cycles, the fault is latched on the last of those edges.
- R3: The catastrophic input needs no qualification. It latches on the first clock edge at which it is sampled high.
- R4: Status byte layout: bit7 is the catastrophic fault. Bit6 is socket A supply and bit5 is socket A programming supply (`sw_oc[3]` and `sw_oc[2]`). Bit4 is socket B supply and bit3 is socket B programming supply (`sw_oc[1]` and `sw_oc[0]`).
- R5: Bit2 of the status byte is 0 when `NUM_CH`=2 and 1 when `NUM_CH`=1. Bits 1 and 0 always read 0. When `NUM_CH`=1, the socket B inputs are ignored.
- R6: A qualified, unmasked fault pulls `alert_n` low on the clock edge where it qualifies. The alert stays low after the fault goes away, until it is cleared.
- R7: Status bits load only while all of them are clear, with every source that qualifies on that edge. Later faults do not change the bits while any bit is set.
- R8: An alert-response pulse with `ara_won`=1 releases the alert and leaves the status bits unchanged. If a fault is still qualified, the alert is pulled low again on the next edge, and the bits are still not reloaded.
- R9: An alert-response pulse with `ara_won`=0 leaves the alert and the status bits unchanged.
- R10: A status-read pulse clears bits 7..3 and releases the alert. A clear wins over a load on the same edge. A fault that persists latches both again on the following edge.
- R11: While `irq_mask` is 1, faults neither pull the alert nor load status bits.
- R12: `pending` is 1 exactly when any of status bits 7..3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_oc | input | 4 | Raw overcurrent reports: [3] A supply, [2] A prog, [1] B supply, [0] B prog |
| cat_flt | input | 1 | Thermal or undervoltage report, unqualified |
| irq_mask | input | 1 | 1 = ignore all faults |
| ara_done | input | 1 | One-cycle pulse: alert-response read finished |
| ara_won | input | 1 | Qualifies `ara_done`: this device won arbitration |
| stat_read_done | input | 1 | One-cycle pulse: last status bit shifted out |
| alert_n | output | 1 | Open-drain alert: 0 = pull low, 1 = release |
| pending | output | 1 | Some status fault bit is latched |
| status | output | 8 | Status byte |

## Verification
The bench builds the main instance with `NUM_CH`=2 and `OC_QUAL_CYC`=3. It builds a second instance with `NUM_CH`=1 and the same inputs. The short qualification window lets every switch be swept with every pulse length from 1 to 6 cycles, so both sides of the threshold are reached. It also lets all 32 combinations of simultaneous faults be applied, masked and unmasked. In those sweeps the catastrophic input's lead over the overcurrent inputs shows first-event capture. The remaining directed sequences cover the alert-response read with won and lost arbitration, and the status read while a fault persists.

// File: rtl/fa_pkg.sv
package fa_pkg;

   // Index of each fault source inside the five-bit latched vector.
   localparam int SRC_W   = 5;
   localparam int SRC_CAT = 4;

   typedef logic [SRC_W-1:0] src_vec_t;

   // Assemble the status byte from the latched sources and the channel-count flag.
   function automatic logic [7:0] pack_status(input src_vec_t bits, input logic single_ch);
      logic [7:0] b;
      b      = '0;
      b[7:3] = bits;
      b[2]   = single_ch;
      return b;
   endfunction

endpackage

// File: rtl/fa_oc_qual.sv
module fa_oc_qual #(
   parameter int QUAL_CYC = 400,
   parameter int CNT_W    = $clog2(QUAL_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic qual
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(QUAL_CYC);

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!raw) begin
         run_q <= '0;
      end else if (run_q != LIM) begin
         run_q <= run_q + 1'b1;
      end
   end

   // High only on an edge where the report has already lasted QUAL_CYC cycles.
   assign qual = raw && (run_q == LIM);
endmodule

// File: rtl/fa_status_latch.sv
module fa_status_latch
   import fa_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t evt_vec,
   input  logic     clr,
   output src_vec_t bits
);
   src_vec_t bits_q;
   logic     empty;

   assign empty = (bits_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (clr) begin
         bits_q <= '0;
      end else if (empty) begin
         bits_q <= evt_vec;
      end
   end

   assign bits = bits_q;
endmodule

// File: rtl/fa_alert_latch.sv
module fa_alert_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ara_clr,
   input  logic ara_won,
   input  logic stat_clr,
   output logic asserted
);
   logic act_q;
   logic drop;

   assign drop = stat_clr || (ara_clr && ara_won);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
      end else if (drop) begin
         act_q <= 1'b0;
      end else if (set) begin
         act_q <= 1'b1;
      end
   end

   assign asserted = act_q;
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
   import fa_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int OC_QUAL_CYC = 400
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] sw_oc,
   input  logic       cat_flt,
   input  logic       irq_mask,
   input  logic       ara_done,
   input  logic       ara_won,
   input  logic       stat_read_done,
   output logic       alert_n,
   output logic       pending,
   output logic [7:0] status
);
   localparam int   NUM_SW = 4;
   localparam int   CNT_W  = $clog2(OC_QUAL_CYC + 1);
   localparam logic SINGLE = (NUM_CH == 1);

   if (NUM_CH != 1 && NUM_CH != 2) begin : g_bad_ch
      $error("fault_alert_ctrl: NUM_CH must be 1 or 2");
   end
   if (OC_QUAL_CYC < 1) begin : g_bad_qual
      $error("fault_alert_ctrl: OC_QUAL_CYC must be at least 1");
   end

   logic [NUM_SW-1:0] oc_qual;
   src_vec_t          src_vec;
   src_vec_t          evt_vec;
   src_vec_t          bits;
   logic              evt_any;
   logic              alert_act;

   // Switches 3 and 2 belong to socket A; 1 and 0 to socket B.
   for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
      if (i >= 2 || NUM_CH == 2) begin : g_live
         fa_oc_qual #(.QUAL_CYC(OC_QUAL_CYC), .CNT_W(CNT_W)) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (sw_oc[i]),
            .qual (oc_qual[i])
         );
      end else begin : g_absent
         assign oc_qual[i] = 1'b0;
      end
   end

   assign src_vec = {cat_flt, oc_qual};
   assign evt_vec = irq_mask ? '0 : src_vec;
   assign evt_any = |evt_vec;

   fa_status_latch u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_vec(evt_vec),
      .clr    (stat_read_done),
      .bits   (bits)
   );

   fa_alert_latch u_alert (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (evt_any),
      .ara_clr (ara_done),
      .ara_won (ara_won),
      .stat_clr(stat_read_done),
      .asserted(alert_act)
   );

   assign alert_n = ~alert_act;
   assign pending = |bits;
   assign status  = pack_status(bits, SINGLE);
endmodule

// File: rtl/fault_alert_chk.sv
module fault_alert_chk #(
   parameter int OC_QUAL_CYC = 400
) (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] sw_oc,
   input logic       irq_mask,
   input logic       ara_done,
   input logic       ara_won,
   input logic       stat_read_done,
   input logic       alert_n,
   input logic       pending,
   input logic [7:0] status
);
   localparam int RW = $clog2(OC_QUAL_CYC + 2) + 1;
   localparam logic [RW-1:0] SAT = RW'(OC_QUAL_CYC + 1);

   // Independent count of consecutive high cycles on the socket A supply report.
   logic [RW-1:0] run_a;
   always_ff @(posedge clk) begin
      if (!rst_n || !sw_oc[3]) run_a <= '0;
      else if (run_a != SAT)   run_a <= run_a + 1'b1;
   end

   a_r2_qualified_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[6]) |-> (run_a == SAT));

   a_r6_alert_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (!alert_n && !ara_done && !stat_read_done) |=> !alert_n);

   a_r7_bits_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !stat_read_done) |=> $stable(status));

   a_r8_ara_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (ara_done && ara_won && !stat_read_done) |=> alert_n);

   a_r9_lost_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!alert_n && ara_done && !ara_won && !stat_read_done) |=> !alert_n);

   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stat_read_done |=> (status[7:3] == 5'b0 && alert_n));

   a_r11_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mask && alert_n && !pending) |=> (alert_n && !pending));

   a_r12_alert_has_bits: assert property (@(posedge clk) disable iff (!rst_n)
      !alert_n |-> pending);
endmodule

bind fault_alert_ctrl fault_alert_chk #(.OC_QUAL_CYC(OC_QUAL_CYC)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sw_oc         (sw_oc),
   .irq_mask      (irq_mask),
   .ara_done      (ara_done),
   .ara_won       (ara_won),
   .stat_read_done(stat_read_done),
   .alert_n       (alert_n),
   .pending       (pending),
   .status        (status)
);

// File: tb/tb_fault_alert_ctrl.sv
module tb_fault_alert_ctrl;
   localparam int Q = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] sw_oc = '0;
   logic       cat_flt = 1'b0, irq_mask = 1'b0;
   logic       ara_done = 1'b0, ara_won = 1'b0, stat_read_done = 1'b0;
   logic       alert_n, pending, alert1_n, pending1;
   logic [7:0] status, status1;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   fault_alert_ctrl #(.NUM_CH(2), .OC_QUAL_CYC(Q)) dut (
      .clk(clk), .rst_n(rst_n), .sw_oc(sw_oc), .cat_flt(cat_flt), .irq_mask(irq_mask),
      .ara_done(ara_done), .ara_won(ara_won), .stat_read_done(stat_read_done),
      .alert_n(alert_n), .pending(pending), .status(status));

   fault_alert_ctrl #(.NUM_CH(1), .OC_QUAL_CYC(Q)) dut_one (
      .clk(clk), .rst_n(rst_n), .sw_oc(sw_oc), .cat_flt(cat_flt), .irq_mask(irq_mask),
      .ara_done(ara_done), .ara_won(ara_won), .stat_read_done(stat_read_done),
      .alert_n(alert1_n), .pending(pending1), .status(status1));

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      sw_oc = '0; cat_flt = 1'b0; irq_mask = 1'b0; ara_done = 1'b0;
      tick();
      stat_read_done = 1'b1;
      tick();
      stat_read_done = 1'b0;
      tick();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] exp;
      tick(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1 alert_n", {7'b0, alert_n}, 8'h01);
      check("R1 pending", {7'b0, pending}, 8'h00);
      check("R1 status", status, 8'h00);
      // R5 single-channel flag
      check("R5 single bit2", status1, 8'h04);

      // R2 / R4 sweep: every switch, every pulse length
      for (int sw = 0; sw < 4; sw++) begin
         for (int len = 1; len <= Q + 3; len++) begin
            sw_oc[sw] = 1'b1;
            tick(len);
            sw_oc[sw] = 1'b0;
            tick(2);
            exp = (len > Q) ? (8'h08 << sw) : 8'h00;
            check($sformatf("R2 R4 sw%0d len%0d status", sw, len), status, exp);
            check($sformatf("R12 sw%0d len%0d pending", sw, len), {7'b0, pending}, {7'b0, exp != 0});
            check($sformatf("R6 sw%0d len%0d alert_n", sw, len), {7'b0, alert_n}, {7'b0, exp == 0});
            clear_all();
         end
      end

      // R3 catastrophic one-cycle pulse
      cat_flt = 1'b1;
      tick();
      cat_flt = 1'b0;
      check("R3 cat immediate", status, 8'h80);
      tick(3);
      check("R6 alert held", {7'b0, alert_n}, 8'h00);
      clear_all();

      // R7 / R5 / R11 sweep over all simultaneous combinations
      for (int v = 0; v < 32; v++) begin
         for (int m = 0; m < 2; m++) begin
            irq_mask = m[0];
            sw_oc = v[3:0];
            cat_flt = v[4];
            tick(Q + 3);
            sw_oc = '0; cat_flt = 1'b0;
            tick();
            if (m == 1) begin
               check($sformatf("R11 v%0d status", v), status, 8'h00);
               check($sformatf("R11 v%0d alert_n", v), {7'b0, alert_n}, 8'h01);
            end else begin
               exp = v[4] ? 8'h80 : {1'b0, v[3:0], 3'b000};
               check($sformatf("R7 v%0d status", v), status, exp);
               check($sformatf("R6 v%0d alert_n", v), {7'b0, alert_n}, {7'b0, v == 0});
               exp = v[4] ? 8'h84 : {1'b0, v[3:2], 5'b00100};
               check($sformatf("R5 v%0d single status", v), status1, exp);
            end
            clear_all();
         end
      end

      // R7 later fault does not reload
      sw_oc[3] = 1'b1;
      tick(Q + 2);
      sw_oc[2] = 1'b1;
      tick(Q + 2);
      check("R7 first only", status, 8'h40);
      // R8 alert-response read won, fault persists
      ara_done = 1'b1; ara_won = 1'b1;
      tick();
      ara_done = 1'b0;
      check("R8 released", {7'b0, alert_n}, 8'h01);
      check("R8 bits kept", status, 8'h40);
      tick();
      check("R8 reasserted", {7'b0, alert_n}, 8'h00);
      check("R8 no reload", status, 8'h40);
      // R9 lost arbitration
      sw_oc = '0;
      tick();
      ara_done = 1'b1; ara_won = 1'b0;
      tick();
      ara_done = 1'b0;
      tick();
      check("R9 alert kept", {7'b0, alert_n}, 8'h00);
      check("R9 bits kept", status, 8'h40);
      // R8 won with fault gone
      ara_done = 1'b1; ara_won = 1'b1;
      tick();
      ara_done = 1'b0;
      tick(2);
      check("R8 stays released", {7'b0, alert_n}, 8'h01);
      check("R12 pending after ara", {7'b0, pending}, 8'h01);
      // R10 status read
      stat_read_done = 1'b1;
      tick();
      stat_read_done = 1'b0;
      check("R10 cleared", status, 8'h00);
      check("R12 pending cleared", {7'b0, pending}, 8'h00);
      // R10 persistent fault relatches
      cat_flt = 1'b1;
      tick(2);
      stat_read_done = 1'b1;
      tick();
      stat_read_done = 1'b0;
      check("R10 clear wins", status, 8'h00);
      check("R10 alert released", {7'b0, alert_n}, 8'h01);
      tick();
      check("R10 relatched", status, 8'h80);
      check("R10 alert again", {7'b0, alert_n}, 8'h00);
      clear_all();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule